// File: doc/BRIEF.md
# SPI Slave Bit Interface with Hold

This block is the bit-level front end of an SPI target device. SCK, the active-low select, the active-low hold and the serial input arrive from pins and are resynchronised into a faster system clock. SCK edges are found in that clock domain. The block assembles incoming serial bits into bytes. It also shifts a byte supplied by a command engine out on the serial output, and it produces a drive enable for an external tristate buffer.

The SCK level when the select goes low decides the clocking mode of the transfer. A low idle level means mode 0 and a high idle level means mode 3. Input bits are captured on rising SCK edges and output bits move on falling SCK edges, most significant bit first.

When the hold input is pulled low, the transfer is frozen: clock and select activity is ignored and the output driver is released. The hold input is only acted on while SCK is low. Opcode decoding and memory access belong to the command engine that sits behind this block.

Top module: `spi_slave_fe`

## Requirements
- R1: `si` is captured on each rising SCK edge. After the eighth rising edge since the select fell, or since the last completed byte, `rx_byte` holds the eight bits with the first one received in bit 7, and `rx_valid` pulses high for exactly one clock.
- R2: Every falling edge of the select, taken while not held, gives a single one-clock pulse on `xfer_start`. `rx_valid` is never high in that same cycle.
- R3: A `tx_load` pulse puts `tx_byte` into the output shifter at once, with bit 7 on `so`. Each later falling SCK edge inside a byte moves the next lower bit onto `so`. The falling edge that comes before the first bit of a byte (bit count zero) leaves `so` unchanged, and `so` does not change at any other time.
- R4: If SCK is high when the select falls (mode 3), the first falling SCK edge shifts nothing. Received and sent data are then the same as in mode 0.
- R5: While the select is high, SCK and `si` activity produces no received byte, and `so_oe` stays low.
- R6: If the select rises partway through a byte, the partial bits are discarded without an `rx_valid` pulse. The next transfer starts counting from zero.
- R7: While hold is in effect, SCK edges and select transitions are ignored, the partial bit count is kept, and `so_oe` is low. Once hold is released, the byte continues where it stopped.
- R8: A change on `hold_n` while SCK is high does not take effect until SCK is low.
- R9: `so_oe` is high only when `rd_drive` is high, the select is active and no hold is in effect.
- R10: After reset, `rx_valid`, `xfer_start` and `so_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the pin |
| cs_n | input | 1 | Active-low select from the pin |
| hold_n | input | 1 | Active-low hold from the pin |
| si | input | 1 | Serial data in |
| tx_byte | input | W | Byte to send next |
| tx_load | input | 1 | Load `tx_byte` into the output shifter |
| rd_drive | input | 1 | Command engine wants the output driven |
| rx_byte | output | W | Last complete received byte |
| rx_valid | output | 1 | One-clock strobe for `rx_byte` |
| xfer_start | output | 1 | One-clock pulse at select fall |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for the `so` buffer |

## Verification
The assertions assume that the pins are slow compared with the system clock. Every SCK level is expected to last several clocks, so that two synchronised edges never fall in the same cycle. They also assume that `tx_load` comes from a command engine reacting to `xfer_start` or `rx_valid`. The stimulus holds each SCK phase for eight system clocks. It changes `si` only while SCK is low, and it moves the select only when SCK is at its idle level. Hold is toggled while SCK is low, except in the one directed case that checks that a hold change with SCK high is deferred.

// File: rtl/spi_slave_fe.sv
module spi_slave_fe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck,
  input  logic         cs_n,
  input  logic         hold_n,
  input  logic         si,
  input  logic [W-1:0] tx_byte,
  input  logic         tx_load,
  input  logic         rd_drive,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid,
  output logic         xfer_start,
  output logic         so,
  output logic         so_oe
);
  localparam int CW = $clog2(W);

  logic [3:0]    m1, m2;
  logic          sck_p, cs_act, hold_act;
  logic [CW-1:0] cnt;
  logic [W-2:0]  rx_sh;
  logic [W-1:0]  tx_sh;

  wire sck_s    = m2[3];
  wire cs_n_s   = m2[2];
  wire hold_n_s = m2[1];
  wire si_s     = m2[0];

  wire run      = cs_act & ~hold_act;
  wire cs_fall  = ~hold_act & ~cs_n_s & ~cs_act;
  wire cs_rise  = ~hold_act & cs_n_s & cs_act;
  wire sck_rise = run & ~cs_rise & sck_s & ~sck_p;
  wire sck_fall = run & ~cs_rise & ~sck_s & sck_p;
  wire last_bit = (cnt == CW'(W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 4'b0110;
      m2 <= 4'b0110;
      sck_p <= 1'b0;
      cs_act <= 1'b0;
      hold_act <= 1'b0;
    end else begin
      m1 <= {sck, cs_n, hold_n, si};
      m2 <= m1;
      sck_p <= sck_s;
      if (!sck_s) hold_act <= ~hold_n_s;
      if (!hold_act) cs_act <= ~cs_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rx_sh <= '0;
      rx_byte <= '0;
      rx_valid <= 1'b0;
      xfer_start <= 1'b0;
    end else begin
      xfer_start <= cs_fall;
      rx_valid <= 1'b0;
      if (cs_fall || cs_rise) begin
        cnt <= '0;
      end else if (sck_rise) begin
        rx_sh <= {rx_sh[W-3:0], si_s};
        cnt <= last_bit ? '0 : cnt + CW'(1);
        if (last_bit) begin
          rx_byte <= {rx_sh, si_s};
          rx_valid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_sh <= '0;
    else if (tx_load) tx_sh <= tx_byte;
    else if (sck_fall && cnt != '0) tx_sh <= {tx_sh[W-2:0], 1'b0};
  end

  assign so    = tx_sh[W-1];
  assign so_oe = run & rd_drive;
endmodule

// File: rtl/spi_slave_fe_chk.sv
module spi_slave_fe_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          xfer_start,
  input logic          so,
  input logic          so_oe,
  input logic          tx_load,
  input logic          sck_fall,
  input logic          hold_act,
  input logic [CW-1:0] cnt
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R1
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R2
  AST_START_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !rx_valid); // R2
  AST_SO_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$past(tx_load) && !$past(sck_fall)) |-> $stable(so)); // R3
  AST_HOLD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && $past(hold_act)) |-> $stable(cnt)); // R7
  AST_HOLD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !so_oe); // R7
endmodule

bind spi_slave_fe spi_slave_fe_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .xfer_start(xfer_start),
  .so(so), .so_oe(so_oe), .tx_load(tx_load), .sck_fall(sck_fall),
  .hold_act(hold_act), .cnt(cnt)
);

// File: tb/spi_slave_fe_tb.sv
`timescale 1ns/1ps
module spi_slave_fe_tb_top;
  localparam int H = 8;
  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, hold_n = 1, si = 0;
  logic [7:0] tx_byte = 0;
  logic tx_load = 0, rd_drive = 0;
  logic [7:0] rx_byte;
  logic rx_valid, xfer_start, so, so_oe;

  spi_slave_fe #(.W(8)) dut_i (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, rx_cnt = 0, st_cnt = 0, tx_idx = 0;
  bit done = 0, m3 = 0;
  logic [7:0] rx_log [0:255];
  logic [7:0] tx_pool [0:7];
  logic [7:0] mosi [0:7];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(posedge clk);
  endtask

  initial forever begin
    @(negedge clk);
    if (rx_valid) begin rx_log[rx_cnt[7:0]] = rx_byte; rx_cnt++; end
    if (xfer_start) st_cnt++;
    tx_load = 0;
    if (xfer_start) tx_idx = 0;
    if (xfer_start || rx_valid) begin
      tx_byte = tx_pool[tx_idx[2:0]];
      tx_idx++;
      tx_load = 1;
    end
  end

  task automatic spi_begin(bit mode3);
    m3 = mode3; sck = mode3; waitc(4);
    cs_n = 0; waitc(H);
  endtask

  task automatic spi_bit(bit b, output bit sob, output bit oe);
    sck = 0; si = b; waitc(H);
    @(negedge clk); sob = so; oe = so_oe;
    sck = 1; waitc(H);
  endtask

  task automatic spi_end();
    if (!m3) begin sck = 0; waitc(H); end
    cs_n = 1; waitc(2*H);
  endtask

  task automatic xfer(bit mode3, int n, bit drv);
    int rx0, st0;
    bit sb, oe, oe_bad;
    logic [7:0] got;
    rx0 = rx_cnt; st0 = st_cnt; oe_bad = 0;
    rd_drive = drv;
    spi_begin(mode3);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_bit(mosi[i][b], sb, oe);
        got[b] = sb;
        if (oe != drv) oe_bad = 1;
      end
      if (drv) chk(got == tx_pool[i], mode3 ? "R4 so byte mode3" : "R3 so byte mode0", got, tx_pool[i]);
    end
    spi_end();
    chk(!oe_bad, "R9 so_oe follows rd_drive", oe_bad, 0);
    chk(st_cnt == st0 + 1, "R2 one xfer_start", st_cnt - st0, 1);
    chk(rx_cnt == rx0 + n, "R1 byte count", rx_cnt - rx0, n);
    for (int i = 0; i < n; i++)
      chk(rx_log[8'(rx0 + i)] === mosi[i], mode3 ? "R1 R4 rx byte" : "R1 rx byte", rx_log[8'(rx0 + i)], mosi[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit sb, oe;
    int rx0, st0;
    logic [7:0] got;
    void'($urandom(32'd1234));
    waitc(3);
    @(negedge clk);
    chk(!rx_valid && !xfer_start && !so_oe, "R10 reset outputs", {rx_valid, xfer_start, so_oe}, 0);
    rst_n = 1; waitc(4);

    mosi[0] = 8'h80; mosi[1] = 8'h01; tx_pool[0] = 8'h81; tx_pool[1] = 8'h7E; tx_pool[2] = 8'h00;
    xfer(0, 2, 1);
    xfer(1, 2, 1);

    for (int t = 0; t < 20; t++) begin
      int n;
      n = 1 + int'($urandom_range(3, 0));
      for (int i = 0; i < 8; i++) begin
        mosi[i] = 8'($urandom); tx_pool[i] = 8'($urandom);
      end
      xfer(1'($urandom), n, 1'($urandom));
    end

    // R5: select high, clock toggles ignored
    rx0 = rx_cnt; rd_drive = 1;
    for (int i = 0; i < 16; i++) begin
      si = 1'($urandom); sck = ~sck; waitc(4);
      chk(!so_oe, "R5 so_oe low while deselected", so_oe, 0);
    end
    sck = 0; waitc(H);
    chk(rx_cnt == rx0, "R5 no byte while deselected", rx_cnt - rx0, 0);

    // R6: partial byte discarded
    rx0 = rx_cnt;
    spi_begin(0);
    for (int b = 0; b < 5; b++) spi_bit(1'b1, sb, oe);
    spi_end();
    chk(rx_cnt == rx0, "R6 partial byte dropped", rx_cnt - rx0, 0);
    mosi[0] = 8'h3C; tx_pool[0] = 8'hC3;
    xfer(0, 1, 1);
    chk(rx_log[8'(rx0)] === 8'h3C, "R6 restart at zero", rx_log[8'(rx0)], 8'h3C);

    // R7 / R8: hold in mid byte
    rx0 = rx_cnt; st0 = st_cnt; rd_drive = 1;
    mosi[0] = 8'hB6; tx_pool[0] = 8'h5A; tx_pool[1] = 8'h00;
    spi_begin(0);
    for (int b = 7; b >= 4; b--) begin spi_bit(mosi[0][b], sb, oe); got[b] = sb; end
    hold_n = 0; waitc(6);
    @(negedge clk);
    chk(so_oe, "R8 hold ignored while SCK high", so_oe, 1);
    hold_n = 1; waitc(4);
    sck = 0; waitc(H);
    hold_n = 0; waitc(6);
    @(negedge clk);
    chk(!so_oe, "R7 so_oe low in hold", so_oe, 0);
    for (int i = 0; i < 3; i++) begin
      sck = 1; si = 1'($urandom); waitc(H); sck = 0; waitc(H);
    end
    cs_n = 1; waitc(H); cs_n = 0; waitc(H);
    hold_n = 1; waitc(6);
    @(negedge clk);
    chk(so_oe, "R7 drive resumes after hold", so_oe, 1);
    for (int b = 3; b >= 0; b--) begin spi_bit(mosi[0][b], sb, oe); got[b] = sb; end
    spi_end();
    chk(got == 8'h5A, "R7 so byte across hold", got, 8'h5A);
    chk(rx_cnt == rx0 + 1, "R7 one byte across hold", rx_cnt - rx0, 1);
    chk(rx_log[8'(rx0)] === 8'hB6, "R7 rx byte across hold", rx_log[8'(rx0)], 8'hB6);
    chk(st_cnt == st0 + 1, "R7 select toggle in hold ignored", st_cnt - st0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule